// File: doc/BRIEF.md
# Mailbox Receive Window Bank

This block is the receive end of a mailbox link. It holds a bank of 32-bit channel windows. A sending agent raises bits in a window through a dedicated set port. Each window carries an interrupt mask that reads back as a 32-bit word. Software sees each window in two forms: the raw status word and the status word with masked bits removed. Software clears status bits by writing ones. It sets or clears mask bits, also by writing ones.

All windows with unmasked set bits are merged into a single receive interrupt, gated by a frame-level enable bit. The same information appears in three other places: a per-window pending vector split across four summary words, a frame status bit, and a side output. The side output gives the index of the lowest-numbered pending window, so a handler can go straight to the right window without scanning the bank.

The register interface is a plain single-cycle strobe interface. A write takes effect at the clock edge where it is sampled. Read data is registered and returned on the following cycle. Addresses are byte addresses on a 32-bit word grid. Bits [11:5] select a window and bits [4:2] select a register inside it. The frame registers sit above the window space.

Top module: `mbx_rx_bank`

## Requirements
- R1: After reset every status word is 0, every mask word is 0xFFFFFFFF, the frame enable bit is 0, `rx_irq` is 0 and `pend_valid` is 0.
- R2: When `snd_valid` is high, `snd_bits` is ORed into the status word of window `snd_win`; the raw status read (window offset 0x00) shows it from the next cycle on.
- R3: The masked status read (window offset 0x04) returns the status word AND NOT the mask word.
- R4: Writing to the status-clear register (window offset 0x08) clears the status bits written as 1; bits written as 0 are unchanged.
- R5: Writing to mask-set (0x14) sets the mask bits written as 1, writing to mask-clear (0x18) clears them, and the mask reads back at offset 0x10.
- R6: When a sender set and a software status clear hit the same bit in the same cycle, the bit ends up set.
- R7: `rx_irq` is high exactly while the frame enable bit (bit 2 of the register at 0xF98) is 1 and some window has a nonzero masked status. Masked bits never raise it, and it falls once every unmasked bit has been cleared.
- R8: `pend_valid` is high while any window has a nonzero masked status, and `pend_idx` then gives the lowest such window number.
- R9: Summary word k (address 0xFA0 + 4k, k = 0..3) has bit j set when window 32k+j has a nonzero masked status. Bit 2 of the frame status register at 0xF90 is set when any window does.
- R10: The configuration register at 0xF80 returns the window count in bits [6:0]. Reserved addresses and write-only registers read as 0. Writes aimed at a window number at or above the window count change nothing.
- R11: Read data appears on `reg_rdata` one cycle after `reg_rd`. It reflects the state before any update made at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_valid | input | 1 | Sender set strobe |
| snd_win | input | IDX_W | Window targeted by the sender |
| snd_bits | input | 32 | Bits to set in that window |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| rx_irq | output | 1 | Receive interrupt |
| pend_valid | output | 1 | Some window has a nonzero masked status |
| pend_idx | output | IDX_W | Lowest pending window number |

## Verification
Sender sets and register writes act at the rising edge where they are sampled. Because `rx_irq`, `pend_valid` and `pend_idx` are decoded only from registers, they are due one cycle after the stimulus. Read data is also due one cycle after the read strobe. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. It compares the interrupt and pending outputs against that model on every falling edge. Each read compares against the model value captured before the edge that samples the read, which also covers a read that coincides with a sender set.

// File: rtl/mbx_rx_pkg.sv
package mbx_rx_pkg;

    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int SUM_WORDS = 4;
    localparam int MAX_WIN   = 124;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_MSTAT,
        SEL_SCLR,
        SEL_MASK,
        SEL_MSET,
        SEL_MCLR,
        SEL_CFG,
        SEL_FSTAT,
        SEL_FCLR,
        SEL_FEN,
        SEL_SUM
    } reg_sel_e;

    // Map a byte address onto the register it names.
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a, input int nwin);
        reg_sel_e s;
        s = SEL_NONE;
        if (int'(a[11:5]) < nwin) begin
            unique case (a[4:2])
                3'd0:    s = SEL_STAT;
                3'd1:    s = SEL_MSTAT;
                3'd2:    s = SEL_SCLR;
                3'd4:    s = SEL_MASK;
                3'd5:    s = SEL_MSET;
                3'd6:    s = SEL_MCLR;
                default: s = SEL_NONE;
            endcase
        end else begin
            unique case (a[11:2])
                10'h3E0: s = SEL_CFG;
                10'h3E4: s = SEL_FSTAT;
                10'h3E5: s = SEL_FCLR;
                10'h3E6: s = SEL_FEN;
                10'h3E8, 10'h3E9, 10'h3EA, 10'h3EB: s = SEL_SUM;
                default: s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/mbx_rx_window.sv
module mbx_rx_window #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] mset_bits,
    input  logic [W-1:0] mclr_bits,
    output logic [W-1:0] status_o,
    output logic [W-1:0] mask_o
);

    logic [W-1:0] status_q;
    logic [W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '1;
        end else begin
            status_q <= (status_q & ~clr_bits) | set_bits;
            mask_q   <= (mask_q | mset_bits) & ~mclr_bits;
        end
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits != '0) |=> ((status_o & $past(set_bits)) == $past(set_bits))); // R6

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_bits & ~set_bits) != '0) |=> ((status_o & $past(clr_bits & ~set_bits)) == '0)); // R4

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((mset_bits & ~mclr_bits) != '0) |=> ((mask_o & $past(mset_bits & ~mclr_bits)) == $past(mset_bits & ~mclr_bits))); // R5

    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mclr_bits != '0) |=> ((mask_o & $past(mclr_bits)) == '0)); // R5

endmodule

// File: rtl/mbx_rx_pend_enc.sv
module mbx_rx_pend_enc #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pend_vec,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top down so the lowest pending window is assigned last.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_vec[i]) idx_o = IDX_W'(i);
        end
    end

    assign valid_o = |pend_vec;

    AST_IDX_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> pend_vec[idx_o]); // R8

    AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((pend_vec & ((N'(1) << idx_o) - N'(1))) == '0)); // R8

endmodule

// File: rtl/mbx_rx_bank.sv
module mbx_rx_bank
    import mbx_rx_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_valid,
    input  logic [IDX_W-1:0]  snd_win,
    input  logic [31:0]       snd_bits,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              rx_irq,
    output logic              pend_valid,
    output logic [IDX_W-1:0]  pend_idx
);

    localparam int SUM_BITS = SUM_WORDS * WORD_W;

    reg_sel_e            sel;
    logic [6:0]          acc_win;
    logic [WORD_W-1:0]   stat_q   [NUM_WIN];
    logic [WORD_W-1:0]   mask_q   [NUM_WIN];
    logic [NUM_WIN-1:0]  pend_vec;
    logic [SUM_BITS-1:0] pend_wide;
    logic [WORD_W-1:0]   pick_stat;
    logic [WORD_W-1:0]   pick_mask;
    logic [WORD_W-1:0]   rdata_d;
    logic [WORD_W-1:0]   rdata_q;
    logic                comb_en_q;

    assign sel     = decode_addr(reg_addr, NUM_WIN);
    assign acc_win = reg_addr[11:5];

    // One status/mask slice per window.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic hit;
        logic [WORD_W-1:0] set_v, clr_v, mset_v, mclr_v;

        assign hit    = reg_wr && (acc_win == 7'(g));
        assign set_v  = (snd_valid && (snd_win == IDX_W'(g))) ? snd_bits : '0;
        assign clr_v  = (hit && sel == SEL_SCLR) ? reg_wdata : '0;
        assign mset_v = (hit && sel == SEL_MSET) ? reg_wdata : '0;
        assign mclr_v = (hit && sel == SEL_MCLR) ? reg_wdata : '0;

        mbx_rx_window #(.W(WORD_W)) u_window (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_bits  (set_v),
            .clr_bits  (clr_v),
            .mset_bits (mset_v),
            .mclr_bits (mclr_v),
            .status_o  (stat_q[g]),
            .mask_o    (mask_q[g])
        );

        assign pend_vec[g] = |(stat_q[g] & ~mask_q[g]);
    end

    always_comb begin
        pend_wide = '0;
        pend_wide[NUM_WIN-1:0] = pend_vec;
    end

    mbx_rx_pend_enc #(.N(NUM_WIN), .IDX_W(IDX_W)) u_pend_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_vec (pend_vec),
        .valid_o  (pend_valid),
        .idx_o    (pend_idx)
    );

    // Frame-level enable for the merged window interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comb_en_q <= 1'b0;
        end else if (reg_wr && sel == SEL_FEN) begin
            comb_en_q <= reg_wdata[2];
        end
    end

    assign rx_irq = comb_en_q & pend_valid;

    // Select the addressed window's words for the read mux.
    always_comb begin
        pick_stat = '0;
        pick_mask = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (acc_win == 7'(i)) begin
                pick_stat = stat_q[i];
                pick_mask = mask_q[i];
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_STAT:  rdata_d = pick_stat;
            SEL_MSTAT: rdata_d = pick_stat & ~pick_mask;
            SEL_MASK:  rdata_d = pick_mask;
            SEL_CFG:   rdata_d = {25'd0, 7'(NUM_WIN)};
            SEL_FSTAT: rdata_d = {29'd0, pend_valid, 2'b00};
            SEL_FEN:   rdata_d = {29'd0, comb_en_q, 2'b00};
            SEL_SUM:   rdata_d = pend_wide[{reg_addr[3:2], 5'd0} +: WORD_W];
            default:   rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            rdata_q <= rdata_d;
        end
    end

    assign reg_rdata = rdata_q;

    AST_EN_OFF_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == SEL_FEN && !reg_wdata[2]) |=> !rx_irq); // R7

    AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        snd_valid |-> (int'(snd_win) < NUM_WIN)); // R2

endmodule

// File: tb/test_mbx_rx_bank.sv
module test_mbx_rx_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          snd_valid = 1'b0;
    logic [IW-1:0] snd_win = '0;
    logic [31:0]   snd_bits = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          rx_irq;
    logic          pend_valid;
    logic [IW-1:0] pend_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] m_st [NW];
    logic [31:0] m_mk [NW];
    bit          m_en;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbx_rx_bank #(.NUM_WIN(NW)) i_mbx_rx_bank (
        .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_win(snd_win),
        .snd_bits(snd_bits), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_irq(rx_irq),
        .pend_valid(pend_valid), .pend_idx(pend_idx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_pend(input int w);
        return (m_st[w] & ~m_mk[w]) != 0;
    endfunction

    function automatic int m_lowest();
        for (int w = 0; w < NW; w++) if (m_pend(w)) return w;
        return -1;
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        int w;
        int off;
        logic [31:0] v;
        w = int'(a[11:5]);
        off = int'(a[4:0]);
        v = 32'h0;
        if (w < NW) begin
            if (off == 0) v = m_st[w];
            else if (off == 4) v = m_st[w] & ~m_mk[w];
            else if (off == 16) v = m_mk[w];
        end else if (a == 12'hF80) v = NW;
        else if (a == 12'hF90) v = (m_lowest() >= 0) ? 32'h4 : 32'h0;
        else if (a == 12'hF98) v = m_en ? 32'h4 : 32'h0;
        else if (a >= 12'hFA0 && a <= 12'hFAC) begin
            for (int b = 0; b < 32; b++) begin
                int ww;
                ww = (int'(a - 12'hFA0) / 4) * 32 + b;
                if (ww < NW && m_pend(ww)) v[b] = 1'b1;
            end
        end
        return v;
    endfunction

    // Reference model: updated at every rising edge from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NW; w++) begin
                m_st[w] = 32'h0;
                m_mk[w] = 32'hFFFF_FFFF;
            end
            m_en = 1'b0;
        end else begin
            for (int w = 0; w < NW; w++) begin
                logic [31:0] s, c, ms, mc;
                s  = (snd_valid && int'(snd_win) == w) ? snd_bits : 32'h0;
                c  = 32'h0;
                ms = 32'h0;
                mc = 32'h0;
                if (reg_wr && int'(reg_addr[11:5]) == w) begin
                    if (reg_addr[4:0] == 5'h08) c  = reg_wdata;
                    if (reg_addr[4:0] == 5'h14) ms = reg_wdata;
                    if (reg_addr[4:0] == 5'h18) mc = reg_wdata;
                end
                m_st[w] = (m_st[w] & ~c) | s;
                m_mk[w] = (m_mk[w] | ms) & ~mc;
            end
            if (reg_wr && reg_addr == 12'hF98) m_en = reg_wdata[2];
        end
    end

    // Every-cycle comparison of the interrupt and pending outputs.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int lo;
            lo = m_lowest();
            chk("R7 rx_irq", 32'(rx_irq), 32'((lo >= 0) && m_en));
            chk("R8 pend_valid", 32'(pend_valid), 32'(lo >= 0));
            if (lo >= 0) chk("R8 pend_idx", 32'(pend_idx), 32'(lo));
        end
    end

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic send(input int w, input logic [31:0] b);
        @(negedge clk);
        snd_valid = 1'b1; snd_win = IW'(w); snd_bits = b;
        @(negedge clk);
        snd_valid = 1'b0;
    endtask

    task automatic send_and_write(input int w, input logic [31:0] b,
                                  input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        snd_valid = 1'b1; snd_win = IW'(w); snd_bits = b;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        snd_valid = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic read_chk(input logic [11:0] a, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        exp = m_read(a);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic read_const(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic read_during_send(input logic [11:0] a, input int w,
                                    input logic [31:0] b, input logic [31:0] exp);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        snd_valid = 1'b1; snd_win = IW'(w); snd_bits = b;
        @(negedge clk);
        reg_rd = 1'b0; snd_valid = 1'b0;
        chk("R11 read before same-edge set", reg_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        read_const(12'h040, 32'h0, "R1 status reset");
        read_const(12'h070, 32'hFFFF_FFFF, "R1 mask reset");
        read_const(12'hF98, 32'h0, "R1 enable reset");
        chk("R1 rx_irq reset", 32'(rx_irq), 32'h0);
        // R10: config, reserved, write-only
        read_const(12'hF80, 32'd8, "R10 config count");
        read_const(12'hF84, 32'h0, "R10 reserved");
        read_const(12'h048, 32'h0, "R10 clear reads zero");
        // R2 / R3: sender set, all masked
        send(2, 32'h0000_00F0);
        read_const(12'h040, 32'h0000_00F0, "R2 raw status");
        read_const(12'h044, 32'h0, "R3 masked while all masked");
        reg_write(12'hF98, 32'h4);
        chk("R7 masked bits silent", 32'(rx_irq), 32'h0);
        // R5: partial unmask
        reg_write(12'h058, 32'h0000_0030);
        read_const(12'h044, 32'h0000_0030, "R3 masked view");
        read_const(12'h050, 32'hFFFF_FFCF, "R5 mask after clear");
        chk("R7 irq raised", 32'(rx_irq), 32'h1);
        chk("R8 idx 2", 32'(pend_idx), 32'd2);
        // R9 / R8: second window pending
        send(5, 32'h0000_0001);
        reg_write(12'h0B8, 32'hFFFF_FFFF);
        read_const(12'hFA0, 32'h0000_0024, "R9 summary word 0");
        read_const(12'hFA4, 32'h0, "R9 summary word 1");
        read_const(12'hF90, 32'h4, "R9 frame status");
        chk("R8 lowest wins", 32'(pend_idx), 32'd2);
        // R4: partial clears
        reg_write(12'h048, 32'h0000_0010);
        read_const(12'h040, 32'h0000_00E0, "R4 clear one bit");
        chk("R7 irq held by remaining bit", 32'(rx_irq), 32'h1);
        reg_write(12'h048, 32'h0000_0020);
        read_chk(12'h044, "R4 masked after clear");
        chk("R8 next window", 32'(pend_idx), 32'd5);
        // R6: set beats clear on the same bit
        send_and_write(5, 32'h0000_0002, 12'h0A8, 32'h0000_0003);
        read_const(12'h0A0, 32'h0000_0002, "R6 set wins");
        reg_write(12'h0A8, 32'hFFFF_FFFF);
        chk("R7 irq falls", 32'(rx_irq), 32'h0);
        // R10: write to window 9 (aliases 1 if truncated) is ignored
        reg_write(12'h138, 32'hFFFF_FFFF);
        read_const(12'h030, 32'hFFFF_FFFF, "R10 out-of-range write ignored");
        // R11: read coincides with sender set
        read_during_send(12'h040, 2, 32'h0000_0001, 32'h0000_00C0);
        read_const(12'h040, 32'h0000_00C1, "R11 set visible after");
        // R5: mask-set, R7: enable off with pending
        reg_write(12'h058, 32'h0000_0001);
        chk("R7 irq from bit 0", 32'(rx_irq), 32'h1);
        reg_write(12'h054, 32'h0000_0001);
        read_chk(12'h050, "R5 mask after set");
        reg_write(12'h058, 32'h0000_0001);
        reg_write(12'hF98, 32'h0);
        chk("R7 enable off", 32'(rx_irq), 32'h0);
        chk("R8 pending without enable", 32'(pend_valid), 32'h1);
        read_chk(12'hF98, "R7 enable readback");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule